// File: doc/BRIEF.md
# Background Self-Calibration Sequencer

This block sets the order of conversion cycles in the digital back end of an oversampling converter while background calibration is selected. Each conversion cycle is marked by a one-clock tick. On every tick the sequencer moves one step through a fixed loop. An offset-calibration step shorts the sampling input. A run of gain-calibration steps connects the sampling input to the reference. A run of filter-refill steps reconnects the analog input. The loop then returns to the offset step. The block drives a 2-bit source select, one-clock strobes that start the offset and gain routines of a separate calibration engine, and an active-low data-ready flag. The flag is low only during an offset step that follows a complete refill run, so one conversion result is published per loop.

The operating mode is a 3-bit field, and background calibration is one code of that field. The sequencer stays in the loop for as long as that code is present when a tick arrives. Any other code sends it to idle on the next tick, with the analog input selected and data-ready high. All pins are plain level or pulse controls. The block carries no data stream, so it has no valid/ready handshake and nothing to back-pressure. The analog front end, the filter arithmetic and the coefficient math sit outside this block and only receive its signals.

Top module: `bgcal_sequencer`

## Requirements
- R1: After reset and before any tick, src_sel is 2'b10 (shorted input), drdy_n is 1 and both strobes are 0. The sequencer is then parked at the offset step.
- R2: Outputs change only on the clock edge at which conv_tick is sampled high. On any other edge src_sel and drdy_n hold, and both strobes are 0.
- R3: A tick taken at the offset step with op_mode equal to 3'b010 (background calibration) enters the gain phase. src_sel becomes 2'b01 (reference) and gain_cal_stb pulses for exactly one clock. The gain phase lasts GAIN_CYCLES ticks (default 3).
- R4: After the last gain tick, src_sel becomes 2'b00 (analog input) for FILL_CYCLES ticks (default 3), with drdy_n high throughout.
- R5: The tick that ends the last refill step returns to the offset step. src_sel becomes 2'b10, drdy_n goes to 0 and offs_cal_stb pulses for one clock. drdy_n returns to 1 on the next tick.
- R6: With background calibration held, drdy_n falls exactly once every 1+GAIN_CYCLES+FILL_CYCLES ticks (7 by default).
- R7: A tick sampled while op_mode is not 3'b010 moves the block to idle, from any step. In idle src_sel is 2'b00, drdy_n is 1 and no strobe is issued, and it stays idle while the mode is not 3'b010.
- R8: A tick with op_mode 3'b010 taken in idle enters the offset step (src_sel 2'b10, offs_cal_stb one clock) but leaves drdy_n at 1, because no refilled result exists yet.
- R9: drdy_n is 0 only while src_sel is 2'b10, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_tick | input | 1 | One-clock pulse per conversion cycle |
| op_mode | input | 3 | Operation mode field; 3'b010 selects background calibration |
| src_sel | output | 2 | Sampling source: 00 analog, 01 reference, 10 shorted |
| offs_cal_stb | output | 1 | One-clock start pulse for offset calibration |
| gain_cal_stb | output | 1 | One-clock start pulse for gain calibration |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
The bench targets the boundaries between phases. If a step counter is off by one, the gain or refill run comes out one tick short or long, and the loop period moves away from seven. It also runs ticks on back-to-back clocks and ticks spread apart, with the mode field toggled between ticks. A design that acted on the mode without a tick would change its outputs on idle clocks. Leaving the loop mid-gain and mid-refill, and re-entering from idle, targets two faults: a design that resumed its old position, and one that flagged data valid on the first offset step after idle.

// File: rtl/bgcal_pkg.sv
package bgcal_pkg;

  typedef enum logic [1:0] {
    SRC_ANALOG = 2'b00,
    SRC_REF    = 2'b01,
    SRC_SHORT  = 2'b10
  } src_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_OFFSET = 2'b01,
    PH_GAIN   = 2'b10,
    PH_FILL   = 2'b11
  } phase_e;

  localparam logic [2:0] MODE_BGCAL = 3'b010;

endpackage

// File: rtl/bgcal_phase_seq.sv
module bgcal_phase_seq
  import bgcal_pkg::*;
#(
  parameter int GAIN_CYCLES = 3,
  parameter int FILL_CYCLES = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   bg_on,
  output phase_e phase_q,
  output logic   ev_idle,
  output logic   ev_ofs_cold,
  output logic   ev_ofs_valid,
  output logic   ev_gain_start,
  output logic   ev_fill_start
);

  localparam int MAXC  = (GAIN_CYCLES > FILL_CYCLES) ? GAIN_CYCLES : FILL_CYCLES;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] GAIN_LAST = CNT_W'(GAIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(FILL_CYCLES - 1);

  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d       = phase_q;
    cnt_d         = cnt_q;
    ev_idle       = 1'b0;
    ev_ofs_cold   = 1'b0;
    ev_ofs_valid  = 1'b0;
    ev_gain_start = 1'b0;
    ev_fill_start = 1'b0;
    if (tick) begin
      if (!bg_on) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
        ev_idle = 1'b1;
      end else begin
        unique case (phase_q)
          PH_IDLE: begin
            phase_d     = PH_OFFSET;
            cnt_d       = '0;
            ev_ofs_cold = 1'b1;
          end
          PH_OFFSET: begin
            phase_d       = PH_GAIN;
            cnt_d         = '0;
            ev_gain_start = 1'b1;
          end
          PH_GAIN: begin
            if (cnt_q == GAIN_LAST) begin
              phase_d       = PH_FILL;
              cnt_d         = '0;
              ev_fill_start = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_FILL: begin
            if (cnt_q == FILL_LAST) begin
              phase_d      = PH_OFFSET;
              cnt_d        = '0;
              ev_ofs_valid = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFFSET;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_GAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_GAIN) |-> (cnt_q <= GAIN_LAST)); // R3
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FILL) |-> (cnt_q <= FILL_LAST)); // R4
  AST_IDLE_ON_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bg_on) |=> (phase_q == PH_IDLE)); // R7
  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q)); // R2

endmodule

// File: rtl/bgcal_out_drv.sv
module bgcal_out_drv
  import bgcal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ev_idle,
  input  logic ev_ofs_cold,
  input  logic ev_ofs_valid,
  input  logic ev_gain_start,
  input  logic ev_fill_start,
  output src_e src_q,
  output logic drdy_nq,
  output logic ofs_stb_q,
  output logic gain_stb_q
);

  src_e src_d;
  logic drdy_d;

  always_comb begin
    src_d  = src_q;
    drdy_d = drdy_nq;
    if (ev_idle) begin
      src_d  = SRC_ANALOG;
      drdy_d = 1'b1;
    end else if (ev_ofs_cold || ev_ofs_valid) begin
      src_d  = SRC_SHORT;
      drdy_d = !ev_ofs_valid;
    end else if (ev_gain_start) begin
      src_d  = SRC_REF;
      drdy_d = 1'b1;
    end else if (ev_fill_start) begin
      src_d  = SRC_ANALOG;
      drdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= SRC_SHORT;
      drdy_nq    <= 1'b1;
      ofs_stb_q  <= 1'b0;
      gain_stb_q <= 1'b0;
    end else begin
      src_q      <= src_d;
      drdy_nq    <= drdy_d;
      ofs_stb_q  <= ev_ofs_cold || ev_ofs_valid;
      gain_stb_q <= ev_gain_start;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(src_q) && $stable(drdy_nq) && !ofs_stb_q && !gain_stb_q)); // R2
  AST_GAIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    gain_stb_q |=> !gain_stb_q); // R3
  AST_OFS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_stb_q |=> !ofs_stb_q); // R5
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ofs_stb_q && gain_stb_q)); // R9

endmodule

// File: rtl/bgcal_sequencer.sv
module bgcal_sequencer
  import bgcal_pkg::*;
#(
  parameter int GAIN_CYCLES = 3,
  parameter int FILL_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_tick,
  input  logic [2:0] op_mode,
  output logic [1:0] src_sel,
  output logic       offs_cal_stb,
  output logic       gain_cal_stb,
  output logic       drdy_n
);

  logic   bg_on;
  phase_e phase;
  logic   ev_idle, ev_ofs_cold, ev_ofs_valid, ev_gain_start, ev_fill_start;
  src_e   src_q;

  assign bg_on = (op_mode == MODE_BGCAL);

  bgcal_phase_seq #(
    .GAIN_CYCLES(GAIN_CYCLES),
    .FILL_CYCLES(FILL_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (conv_tick),
    .bg_on        (bg_on),
    .phase_q      (phase),
    .ev_idle      (ev_idle),
    .ev_ofs_cold  (ev_ofs_cold),
    .ev_ofs_valid (ev_ofs_valid),
    .ev_gain_start(ev_gain_start),
    .ev_fill_start(ev_fill_start)
  );

  bgcal_out_drv u_drv (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (conv_tick),
    .ev_idle      (ev_idle),
    .ev_ofs_cold  (ev_ofs_cold),
    .ev_ofs_valid (ev_ofs_valid),
    .ev_gain_start(ev_gain_start),
    .ev_fill_start(ev_fill_start),
    .src_q        (src_q),
    .drdy_nq      (drdy_n),
    .ofs_stb_q    (offs_cal_stb),
    .gain_stb_q   (gain_cal_stb)
  );

  assign src_sel = src_q;

  AST_DRDY_SHORTED: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy_n |-> (src_sel == SRC_SHORT)); // R9
  AST_OFS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    offs_cal_stb |-> (src_sel == SRC_SHORT && phase == PH_OFFSET)); // R5
  AST_GAIN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    gain_cal_stb |-> (src_sel == SRC_REF && phase == PH_GAIN)); // R3
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_tick && !bg_on) |=> (src_sel == SRC_ANALOG && drdy_n && !offs_cal_stb && !gain_cal_stb)); // R7
  AST_COLD_NO_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_tick && bg_on && phase == PH_IDLE) |=> drdy_n); // R8

endmodule

// File: tb/tb_bgcal_sequencer.sv
module tb_bgcal_sequencer;

  localparam int G = 3;
  localparam int F = 3;
  localparam logic [2:0] BG = 3'b010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_tick = 1'b0;
  logic [2:0] op_mode = BG;
  logic [1:0] src_sel;
  logic       offs_cal_stb, gain_cal_stb, drdy_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bgcal_sequencer #(.GAIN_CYCLES(G), .FILL_CYCLES(F)) dut (
    .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .op_mode(op_mode),
    .src_sel(src_sel), .offs_cal_stb(offs_cal_stb),
    .gain_cal_stb(gain_cal_stb), .drdy_n(drdy_n)
  );

  always #4 clk = ~clk;

  // Behavioural reference: pos -1 idle, 0 offset, 1..G gain, G+1..G+F fill
  int    pos = 0;
  int    e_sel = 2;
  bit    e_dr = 1'b1, e_o = 1'b0, e_g = 1'b0;
  string tag = "R1";
  bit    seen_tick = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = 0; e_sel = 2; e_dr = 1'b1; e_o = 1'b0; e_g = 1'b0; tag = "R1";
    end else begin
      e_o = 1'b0; e_g = 1'b0;
      if (!conv_tick) begin
        if (seen_tick) tag = "R2";
      end else begin
        seen_tick = 1'b1;
        if (op_mode != BG) begin
          pos = -1; e_sel = 0; e_dr = 1'b1; tag = "R7";
        end else if (pos == -1) begin
          pos = 0; e_sel = 2; e_dr = 1'b1; e_o = 1'b1; tag = "R8";
        end else if (pos == 0) begin
          pos = 1; e_sel = 1; e_dr = 1'b1; e_g = 1'b1; tag = "R3";
        end else if (pos < G) begin
          pos++; tag = "R3";
        end else if (pos < G + F) begin
          pos++; e_sel = 0; tag = "R4";
        end else begin
          pos = 0; e_sel = 2; e_dr = 1'b0; e_o = 1'b1; tag = "R5";
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (src_sel !== 2'(e_sel) || drdy_n !== e_dr ||
          offs_cal_stb !== e_o || gain_cal_stb !== e_g) begin
        fails++;
        $display("FAIL %s: sel=%0d drdy_n=%0b ofs=%0b gain=%0b expected sel=%0d drdy_n=%0b ofs=%0b gain=%0b",
                 tag, src_sel, drdy_n, offs_cal_stb, gain_cal_stb, e_sel, e_dr, e_o, e_g);
      end
      checks++;
      if (!drdy_n && src_sel !== 2'b10) begin // R9
        fails++;
        $display("FAIL R9: drdy_n low with sel=%0d expected 2", src_sel);
      end
      checks++;
      if (offs_cal_stb && gain_cal_stb) begin // R9
        fails++;
        $display("FAIL R9: both strobes high, expected at most one");
      end
    end
  end

  task automatic tick_gap(input int gap);
    @(negedge clk) conv_tick = 1'b1;
    @(negedge clk) conv_tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic tick_run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) conv_tick = 1'b1;
    end
    @(negedge clk) conv_tick = 1'b0;
  endtask

  int  falls;
  bit  prev_dr;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk); // R1 held with no tick

    // spread ticks, mode toggled between ticks (R2)
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) op_mode = 3'b110;
      @(negedge clk) op_mode = BG;
      tick_gap(i % 3);
    end

    // back-to-back ticks (R3, R4, R5)
    tick_run(25);

    // leave mid-gain, idle for a while, return (R7, R8)
    while (!(gain_cal_stb)) tick_gap(0);
    op_mode = 3'b000;
    tick_gap(1);
    tick_gap(2);
    op_mode = BG;
    tick_run(5); // offset cold, gain, partway into refill
    op_mode = 3'b111; // leave mid-refill
    tick_gap(0);
    op_mode = BG;

    // R6: from idle, 71 back-to-back ticks yield 10 drdy falls
    op_mode = 3'b001;
    tick_gap(1);
    op_mode = BG;
    falls = 0;
    prev_dr = drdy_n;
    for (int i = 0; i < 71; i++) begin
      @(negedge clk) conv_tick = 1'b1;
      if (prev_dr && !drdy_n) falls++;
      prev_dr = drdy_n;
    end
    @(negedge clk) conv_tick = 1'b0;
    if (prev_dr && !drdy_n) falls++;
    checks++;
    if (falls != 10) begin
      fails++;
      $display("FAIL R6: drdy falls=%0d expected 10", falls);
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule